// File: doc/BRIEF.md
# PCI Target Termination Controller

This block is the target side of a simple 32-bit PCI device. It watches the initiator's FRAME#, IRDY#, command/byte-enable and address/data lines, decides whether a cycle belongs to it, and drives DEVSEL#, TRDY# and STOP#. A claimed cycle ends in one of three ways. It can complete normally. It can be refused with a disconnect-retry while an internal busy window is open. If the initiator tries a burst, only the first data phase is accepted and the rest is disconnected.

Two internal windows make the device busy. The first is a configuration-load window that models reading a serial EEPROM. It opens by itself when reset is released, and software can reopen it through a control register. The second is a soft-reset window. It opens when software reads a dedicated register in the I/O/memory window and lasts a set number of clocks. The EEPROM serial protocol is not modelled: a counter stands in for its timing. A small register backend gives software something to read and write. The bus pins are presented as separate inputs, outputs and output-enables, so the pad ring can build the tri-state buffers.

Top module: `pci_tgt_term`

## Requirements
- R1: After synchronous reset, ctl_oe and ad_oe are 0 and DEVSEL#, TRDY# and STOP# are high. The I/O-enable and memory-enable bits are cleared. The configuration-load window opens as reset is released.
- R2: For a claimed cycle whose address is sampled at clock edge A, DEVSEL# goes low after edge A+2 and TRDY# goes low no earlier than after edge A+3. A data phase completes at an edge where both TRDY# and IRDY# are low.
- R3: A configuration cycle is claimed when IDSEL is high, AD[1:0]=00 and the command is 1010 (read) or 1011 (write). Configuration offset 0x00 reads ID_WORD. Offset 0x04 holds bit 0 = I/O enable and bit 1 = memory enable, and it is written when byte enable 0 is active.
- R4: An I/O cycle (command 0010/0011) is claimed only when the I/O-enable bit is set and AD[31:4] equals IO_BASE[31:4]. A memory cycle (command 0110/0111) is claimed only when the memory-enable bit is set and AD[31:4] equals MEM_BASE[31:4]. An unclaimed cycle never sees DEVSEL# low.
- R5: The I/O/memory window is decoded on AD[3:2]. Word 0 is a scratch register written per active-low byte enable. In word 1, writing bit 0 = 1 reopens the configuration-load window. Reading word 2 returns 0, opens the soft-reset window and clears the scratch register. Word 3 reads TAG_WORD.
- R6: While the configuration-load window is open (EE_CYCLES clocks), every claimed cycle is answered with DEVSEL# and STOP# low and TRDY# high, and no register changes.
- R7: While the soft-reset window is open (SRST_CYCLES clocks after the reading data phase), I/O and memory cycles are retried as in R6. Configuration cycles are still served.
- R8: Once STOP# is low it stays low until the clock after the edge at which FRAME# is sampled high.
- R9: If FRAME# and IRDY# are both low at the edge before TRDY# is asserted, STOP# is asserted together with TRDY#. Only the first data phase completes, and a burst that keeps FRAME# low after a completed phase is disconnected.
- R10: After a claimed cycle, DEVSEL#, TRDY# and STOP# are driven high with ctl_oe=1 for one clock, and then ctl_oe goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | Command in the address phase, byte enables in the data phase |
| ad_in | input | 32 | Address/data in |
| ad_out | output | 32 | Read data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| ctl_oe | output | 1 | Drive enable for DEVSEL#, TRDY#, STOP# |

## Verification
A busy counter stuck open turns every claimed access into a retry. This is visible within four clocks of the next address phase. A window that closes early lets through a cycle that should have been retried, and a register reread then shows a changed value. A wrong decoder or state sequence shows up at once as DEVSEL# or TRDY# one clock off, a missing STOP#, or a second accepted burst phase. A read-back after the cycle exposes that extra phase. A lost enable bit or soft-reset side effect shows up on the next access as an unclaimed cycle or a wrong scratch value.

// File: rtl/pci_tgt_pkg.sv
// Shared types and constants for the PCI target termination block.
// Assumes a 16-byte I/O/memory register window (four 32-bit words).
package pci_tgt_pkg;

    localparam int WIN_BITS = 4;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [1:0] {
        SP_NONE,
        SP_CFG,
        SP_IO,
        SP_MEM
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEC1,
        ST_DEC2,
        ST_CLAIM,
        ST_DATA,
        ST_HOLD,
        ST_TURN,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/pci_tgt_busy.sv
// Busy-window timers. The configuration-load window opens at reset and on
// ee_start; the soft-reset window opens on srst_start. Each lasts a fixed
// number of clocks. Assumes start pulses are single-cycle.
module pci_tgt_busy #(
    parameter int EE_CYCLES   = 40,
    parameter int SRST_CYCLES = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ee_start,
    input  logic srst_start,
    output logic ee_busy,
    output logic srst_busy
);
    localparam int EE_W = $clog2(EE_CYCLES + 1);
    localparam int SR_W = $clog2(SRST_CYCLES + 1);

    logic [EE_W-1:0] ee_cnt;
    logic [SR_W-1:0] sr_cnt;

    // Configuration-load countdown, loaded by reset or software request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ee_cnt <= EE_W'(EE_CYCLES);
        else if (ee_start)
            ee_cnt <= EE_W'(EE_CYCLES);
        else if (ee_cnt != '0)
            ee_cnt <= ee_cnt - 1'b1;
    end

    // Soft-reset countdown, loaded by a read of the reset register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_cnt <= '0;
        else if (srst_start)
            sr_cnt <= SR_W'(SRST_CYCLES);
        else if (sr_cnt != '0)
            sr_cnt <= sr_cnt - 1'b1;
    end

    assign ee_busy   = (ee_cnt != '0);
    assign srst_busy = (sr_cnt != '0);

    // R6: a software request opens the load window on the next clock.
    assert_ee_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ee_start |=> ee_busy);

    // R7: a reset-register read opens the soft-reset window on the next clock.
    assert_srst_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srst_start |=> srst_busy);

endmodule

// File: rtl/pci_tgt_regs.sv
// Register backend. Serves configuration offsets 0x00/0x04 and a four-word
// I/O/memory window (scratch, control, reset trigger, tag). Assumes wr_en and
// rd_done are single-cycle pulses from completed data phases only.
module pci_tgt_regs
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] ID_WORD  = 32'hC0DE_0A11,
    parameter logic [31:0] TAG_WORD = 32'h5A5A_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  space_e      space,
    input  logic [5:0]  idx,
    input  logic        wr_en,
    input  logic        rd_done,
    input  logic [31:0] wdata,
    input  logic [3:0]  be_n,
    output logic [31:0] rdata,
    output logic        io_en,
    output logic        mem_en,
    output logic        ee_kick,
    output logic        srst_kick
);
    logic [31:0] scratch;
    logic        win;

    assign win       = (space == SP_IO) || (space == SP_MEM);
    assign ee_kick   = wr_en && win && (idx[1:0] == 2'd1) && !be_n[0] && wdata[0];
    assign srst_kick = rd_done && win && (idx[1:0] == 2'd2);

    // Command register enables, cleared by hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_en  <= 1'b0;
            mem_en <= 1'b0;
        end else if (wr_en && space == SP_CFG && idx == 6'd1 && !be_n[0]) begin
            io_en  <= wdata[0];
            mem_en <= wdata[1];
        end
    end

    // Scratch word: byte-enabled writes, cleared by a soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_kick)
            scratch <= '0;
        else if (wr_en && win && idx[1:0] == 2'd0) begin
            for (int b = 0; b < 4; b++)
                if (!be_n[b]) scratch[8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    // Read multiplexer for the latched space and word index.
    always_comb begin
        rdata = '0;
        if (space == SP_CFG) begin
            if (idx == 6'd0) rdata = ID_WORD;
            else if (idx == 6'd1) rdata = {30'd0, mem_en, io_en};
        end else if (win) begin
            if (idx[1:0] == 2'd0) rdata = scratch;
            else if (idx[1:0] == 2'd3) rdata = TAG_WORD;
        end
    end

    // R5: the soft-reset trigger leaves the scratch word cleared.
    assert_scratch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        srst_kick |=> (scratch == '0));

endmodule

// File: rtl/pci_tgt_fsm.sv
// Target sequencer. Medium decode: DEVSEL# two clocks after the address edge,
// TRDY# or STOP# one clock later. Handles normal completion, retry, burst
// disconnect and a one-clock high turnaround. Assumes a well-behaved initiator.
module pci_tgt_fsm
    import pci_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic addr_hit,
    input  logic retry_now,
    output logic addr_phase,
    output logic data_phase,
    output logic xfer,
    output logic devsel_n,
    output logic trdy_n,
    output logic stop_n,
    output logic ctl_oe
);
    tgt_state_e state_q, state_d;
    logic       burst_q, burst_d;

    // Next-state and burst-flag decision.
    always_comb begin
        state_d = state_q;
        burst_d = burst_q;
        unique case (state_q)
            ST_IDLE:  if (!frame_n) state_d = addr_hit ? ST_DEC1 : ST_SKIP;
            ST_SKIP:  if (frame_n && irdy_n) state_d = ST_IDLE;
            ST_DEC1:  state_d = ST_DEC2;
            ST_DEC2:  state_d = ST_CLAIM;
            ST_CLAIM: begin
                if (retry_now) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_DATA;
                    burst_d = !frame_n && !irdy_n;
                end
            end
            ST_DATA:  if (!irdy_n) state_d = frame_n ? ST_TURN : ST_HOLD;
            ST_HOLD:  if (frame_n) state_d = ST_TURN;
            ST_TURN: begin
                state_d = ST_IDLE;
                burst_d = 1'b0;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            burst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            burst_q <= burst_d;
        end
    end

    assign addr_phase = (state_q == ST_IDLE) && !frame_n;
    assign data_phase = (state_q == ST_DATA);
    assign xfer       = (state_q == ST_DATA) && !irdy_n;
    assign devsel_n   = !(state_q == ST_CLAIM || state_q == ST_DATA || state_q == ST_HOLD);
    assign trdy_n     = (state_q != ST_DATA);
    assign stop_n     = !(state_q == ST_HOLD || (state_q == ST_DATA && burst_q));
    assign ctl_oe     = (state_q == ST_CLAIM) || (state_q == ST_DATA) ||
                        (state_q == ST_HOLD)  || (state_q == ST_TURN);

    // R2: DEVSEL# falls exactly three samples after the address edge.
    assert_medium_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> !$past(frame_n, 3));

    // R2: TRDY# never falls unless DEVSEL# was already low.
    assert_trdy_after_devsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> !$past(devsel_n));

    // R6: a retry (STOP# without TRDY#) always carries DEVSEL#.
    assert_retry_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && trdy_n) |-> !devsel_n);

    // R8: STOP# holds while the initiator keeps FRAME# low.
    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !frame_n) |=> !stop_n);

    // R10: drivers are released only after a clock of driven-high outputs.
    assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_oe) |-> ($past(devsel_n) && $past(trdy_n) && $past(stop_n)));

endmodule

// File: rtl/pci_tgt_term.sv
// Top of the PCI target termination block. Decodes the address phase, latches
// the target space, and joins the sequencer, busy timers and registers.
// Assumes type-0 configuration cycles and separate pad-level drive enables.
module pci_tgt_term
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] ID_WORD     = 32'hC0DE_0A11,
    parameter logic [31:0] TAG_WORD    = 32'h5A5A_0001,
    parameter logic [31:0] IO_BASE     = 32'h0000_1000,
    parameter logic [31:0] MEM_BASE    = 32'h8000_0000,
    parameter int          EE_CYCLES   = 40,
    parameter int          SRST_CYCLES = 33
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        ctl_oe
);
    space_e     sp_dec, space_q;
    logic       addr_hit, wr_q, io_en, mem_en;
    logic [5:0] idx_q;
    logic       addr_phase, data_phase, xfer, retry_now;
    logic       ee_busy, srst_busy, ee_kick, srst_kick, wr_en, rd_done;

    // Address-phase command decode into a target space.
    always_comb begin
        unique case (cbe_n)
            CMD_IO_RD,  CMD_IO_WR:  sp_dec = SP_IO;
            CMD_MEM_RD, CMD_MEM_WR: sp_dec = SP_MEM;
            CMD_CFG_RD, CMD_CFG_WR: sp_dec = SP_CFG;
            default:                sp_dec = SP_NONE;
        endcase
    end

    // Claim decision from space, enables and address match.
    always_comb begin
        unique case (sp_dec)
            SP_CFG:  addr_hit = idsel && (ad_in[1:0] == 2'b00);
            SP_IO:   addr_hit = io_en  && (ad_in[31:WIN_BITS] == IO_BASE[31:WIN_BITS]);
            SP_MEM:  addr_hit = mem_en && (ad_in[31:WIN_BITS] == MEM_BASE[31:WIN_BITS]);
            default: addr_hit = 1'b0;
        endcase
    end

    // Latch space, direction and word index during the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q <= SP_NONE;
            wr_q    <= 1'b0;
            idx_q   <= '0;
        end else if (addr_phase) begin
            space_q <= sp_dec;
            wr_q    <= cbe_n[0];
            idx_q   <= ad_in[7:2];
        end
    end

    assign retry_now = ee_busy || (srst_busy && space_q != SP_CFG);
    assign wr_en     = xfer && wr_q;
    assign rd_done   = xfer && !wr_q;
    assign ad_oe     = data_phase && !wr_q;

    pci_tgt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .addr_hit   (addr_hit),
        .retry_now  (retry_now),
        .addr_phase (addr_phase),
        .data_phase (data_phase),
        .xfer       (xfer),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n),
        .ctl_oe     (ctl_oe)
    );

    pci_tgt_busy #(
        .EE_CYCLES   (EE_CYCLES),
        .SRST_CYCLES (SRST_CYCLES)
    ) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .ee_start   (ee_kick),
        .srst_start (srst_kick),
        .ee_busy    (ee_busy),
        .srst_busy  (srst_busy)
    );

    pci_tgt_regs #(
        .ID_WORD  (ID_WORD),
        .TAG_WORD (TAG_WORD)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .space     (space_q),
        .idx       (idx_q),
        .wr_en     (wr_en),
        .rd_done   (rd_done),
        .wdata     (ad_in),
        .be_n      (cbe_n),
        .rdata     (ad_out),
        .io_en     (io_en),
        .mem_en    (mem_en),
        .ee_kick   (ee_kick),
        .srst_kick (srst_kick)
    );

    // R6: nothing is written during a retry.
    assert_no_write_on_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && trdy_n) |-> !wr_en);

    // R4: with both enables clear, only configuration cycles may be claimed.
    assert_claim_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && addr_hit && !io_en && !mem_en) |-> (sp_dec == SP_CFG));

endmodule

// File: tb/pci_tgt_term_tb.sv
`timescale 1ns/1ps
module pci_tgt_term_tb;
    localparam logic [31:0] ID_W   = 32'hC0DE_0A11;
    localparam logic [31:0] TAG_W  = 32'h5A5A_0001;
    localparam logic [31:0] IOB    = 32'h0000_1000;
    localparam logic [31:0] MEMB   = 32'h8000_0000;
    localparam int          EE_N   = 40;
    localparam int          SRST_N = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;

    int total = 0, bad = 0;
    bit finished = 0;

    // Cycle results
    int          r_dev_at, r_trdy_at, r_xfers;
    bit          r_stop, r_stop_with_trdy, r_held, r_turn, r_rel;
    logic [31:0] r_rdata;

    pci_tgt_term #(
        .ID_WORD(ID_W), .TAG_WORD(TAG_W), .IO_BASE(IOB), .MEM_BASE(MEMB),
        .EE_CYCLES(EE_N), .SRST_CYCLES(SRST_N)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .ctl_oe(ctl_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One initiator transaction; samples target outputs at negedges.
    task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr,
                             input logic [31:0] wdat, input logic [3:0] be,
                             input bit sel, input bit burst);
        bit done = 0;
        int n = 1;
        r_dev_at = 0; r_trdy_at = 0; r_xfers = 0; r_stop = 0;
        r_stop_with_trdy = 0; r_held = 0; r_turn = 0; r_rel = 0; r_rdata = '0;
        @(negedge clk);
        frame_n = 1'b0; ad_in = addr; cbe_n = cmd; idsel = sel;
        @(negedge clk);
        irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1; cbe_n = be; ad_in = wdat; idsel = 1'b0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
            if (!devsel_n && r_dev_at == 0) r_dev_at = n;
            if (!trdy_n) begin
                r_xfers++; r_trdy_at = n; r_rdata = ad_out;
                if (!stop_n) r_stop_with_trdy = 1;
                if (frame_n) begin
                    @(negedge clk);
                    r_turn = ctl_oe && devsel_n && trdy_n && stop_n;
                    irdy_n = 1'b1;
                end else begin
                    @(negedge clk);
                    r_held = !stop_n && trdy_n && !devsel_n;
                    if (!trdy_n) r_xfers++;
                    frame_n = 1'b1; ad_in = ~wdat;
                    @(negedge clk);
                    r_turn = ctl_oe && devsel_n && trdy_n && stop_n;
                    irdy_n = 1'b1;
                end
                done = 1;
            end else if (!stop_n) begin
                r_stop = 1;
                frame_n = 1'b1;
                @(negedge clk);
                r_turn = ctl_oe && devsel_n && trdy_n && stop_n;
                irdy_n = 1'b1;
                done = 1;
            end
        end
        if (!done) begin
            frame_n = 1'b1;
            @(negedge clk);
            irdy_n = 1'b1;
        end
        @(negedge clk);
        r_rel = !ctl_oe;
        cbe_n = 4'hF;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!ctl_oe && !ad_oe && devsel_n && trdy_n && stop_n, "R1", "outputs in reset",
            {27'd0, ctl_oe, ad_oe, devsel_n, trdy_n, stop_n}, 32'h7);
        rst_n = 1'b1;
    endtask

    task automatic t_load_after_reset;
        bus_cycle(4'b1011, 32'h0000_0004, 32'h3, 4'h0, 1, 0);
        chk(r_stop && r_xfers == 0 && r_dev_at == 3, "R6", "config retried in reset load",
            {r_stop, 7'd0, 8'(r_xfers), 8'(r_dev_at)}, {1'b1, 7'd0, 8'd0, 8'd3});
        chk(r_turn && r_rel, "R10", "turnaround after retry", {r_turn, r_rel}, 2'b11);
        bus_cycle(4'b0010, IOB, 0, 4'h0, 0, 0);
        chk(r_dev_at == 0, "R1", "I/O unclaimed with enables cleared", r_dev_at, 0);
        repeat (EE_N + 5) @(negedge clk);
        bus_cycle(4'b1010, 32'h0000_0004, 0, 4'h0, 1, 0);
        chk(r_rdata == 32'h0, "R1", "command bits clear after reset", r_rdata, 0);
        chk(r_rdata == 32'h0, "R6", "retried write left command unchanged", r_rdata, 0);
    endtask

    task automatic t_config;
        bus_cycle(4'b1010, 32'h0000_0000, 0, 4'h0, 1, 0);
        chk(r_rdata == ID_W, "R3", "config ID read", r_rdata, ID_W);
        chk(r_dev_at == 3, "R2", "DEVSEL timing", r_dev_at, 3);
        chk(r_trdy_at == 4 && r_xfers == 1, "R2", "TRDY timing",
            r_trdy_at, 4);
        chk(r_turn && r_rel, "R10", "turnaround after read", {r_turn, r_rel}, 2'b11);
        bus_cycle(4'b1010, 32'h0000_0000, 0, 4'h0, 0, 0);
        chk(r_dev_at == 0, "R3", "config without IDSEL unclaimed", r_dev_at, 0);
        bus_cycle(4'b1011, 32'h0000_0004, 32'h3, 4'h0, 1, 0);
        bus_cycle(4'b1010, 32'h0000_0004, 0, 4'h0, 1, 0);
        chk(r_rdata == 32'h3, "R3", "command write read-back", r_rdata, 32'h3);
    endtask

    task automatic t_window;
        bus_cycle(4'b0011, IOB, 32'h1122_3344, 4'h0, 0, 0);
        bus_cycle(4'b0010, IOB, 0, 4'h0, 0, 0);
        chk(r_rdata == 32'h1122_3344, "R5", "scratch via I/O", r_rdata, 32'h1122_3344);
        bus_cycle(4'b0111, MEMB, 32'hAABB_CCDD, 4'b1100, 0, 0);
        bus_cycle(4'b0110, MEMB, 0, 4'h0, 0, 0);
        chk(r_rdata == 32'h1122_CCDD, "R5", "byte-enabled scratch via memory",
            r_rdata, 32'h1122_CCDD);
        bus_cycle(4'b0010, IOB + 32'hC, 0, 4'h0, 0, 0);
        chk(r_rdata == TAG_W, "R5", "tag word", r_rdata, TAG_W);
        bus_cycle(4'b0010, IOB + 32'h10, 0, 4'h0, 0, 0);
        chk(r_dev_at == 0, "R4", "I/O outside window unclaimed", r_dev_at, 0);
    endtask

    task automatic t_burst;
        bus_cycle(4'b0011, IOB, 32'hCAFE_F00D, 4'h0, 0, 1);
        chk(r_stop_with_trdy, "R9", "STOP with TRDY on burst", r_stop_with_trdy, 1);
        chk(r_xfers == 1, "R9", "one burst phase", r_xfers, 1);
        chk(r_held, "R8", "STOP held while FRAME low", r_held, 1);
        chk(r_turn && r_rel, "R10", "turnaround after burst", {r_turn, r_rel}, 2'b11);
        bus_cycle(4'b0010, IOB, 0, 4'h0, 0, 0);
        chk(r_rdata == 32'hCAFE_F00D, "R9", "only first burst data stored",
            r_rdata, 32'hCAFE_F00D);
    endtask

    task automatic t_sw_load;
        bus_cycle(4'b0011, IOB + 32'h4, 32'h1, 4'h0, 0, 0);
        bus_cycle(4'b0011, IOB, 32'h0BAD_0BAD, 4'h0, 0, 0);
        chk(r_stop && r_xfers == 0, "R6", "write retried in software load",
            {r_stop, 8'(r_xfers)}, {1'b1, 8'd0});
        bus_cycle(4'b1010, 32'h0000_0000, 0, 4'h0, 1, 0);
        chk(r_stop && r_xfers == 0, "R6", "config retried in software load", r_stop, 1);
        repeat (EE_N + 5) @(negedge clk);
        bus_cycle(4'b0010, IOB, 0, 4'h0, 0, 0);
        chk(r_xfers == 1 && r_rdata == 32'hCAFE_F00D, "R6", "retried write had no effect",
            r_rdata, 32'hCAFE_F00D);
    endtask

    task automatic t_soft_reset;
        bus_cycle(4'b0010, IOB + 32'h8, 0, 4'h0, 0, 0);
        chk(r_xfers == 1 && r_rdata == 32'h0, "R5", "reset register reads zero", r_rdata, 0);
        bus_cycle(4'b0110, MEMB, 0, 4'h0, 0, 0);
        chk(r_stop && r_xfers == 0, "R7", "memory retried in soft reset", r_stop, 1);
        bus_cycle(4'b1010, 32'h0000_0000, 0, 4'h0, 1, 0);
        chk(r_xfers == 1 && r_rdata == ID_W, "R7", "config served in soft reset",
            r_rdata, ID_W);
        repeat (SRST_N + 5) @(negedge clk);
        bus_cycle(4'b0010, IOB, 0, 4'h0, 0, 0);
        chk(r_xfers == 1 && r_rdata == 32'h0, "R5", "soft reset cleared scratch", r_rdata, 0);
    endtask

    task automatic t_disable;
        bus_cycle(4'b1011, 32'h0000_0004, 32'h1, 4'h0, 1, 0);
        bus_cycle(4'b0110, MEMB, 0, 4'h0, 0, 0);
        chk(r_dev_at == 0, "R4", "memory unclaimed when disabled", r_dev_at, 0);
        bus_cycle(4'b0010, IOB + 32'hC, 0, 4'h0, 0, 0);
        chk(r_rdata == TAG_W, "R4", "I/O still claimed", r_rdata, TAG_W);
    endtask

    initial begin
        t_reset();
        t_load_after_reset();
        t_config();
        t_window();
        t_burst();
        t_sw_load();
        t_soft_reset();
        t_disable();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule